// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer

A memory-mapped timer holding several independent 32-bit channels. Each channel counts ticks of a slow reference clock, divided by a prescaler that its control word selects. When a channel's count reaches its compare value on a count tick, the channel sets a match flag. It can then either return to zero, which gives periodic operation, or keep counting freely. The match flag drives the channel's interrupt line or its DMA request line, depending on the request type chosen in the control word. A single run register at byte address 0 holds one run bit per channel. Software starts or stops one channel by read-modify-write of that register.

The register bus is synchronous to the bus clock `clk`. The reference clock `ref_clk` is sampled into the bus domain by a two-stage synchroniser. Each rising edge of `ref_clk` becomes a one-cycle reference tick. A write to a channel counter does not apply at once. A small state machine per channel holds the written value in the states LAG_IDLE, LAG_WAIT_FIRST and LAG_WAIT_SECOND. Its transitions are:
- A counter write moves any state to LAG_WAIT_FIRST.
- A reference tick moves LAG_WAIT_FIRST to LAG_WAIT_SECOND.
- A reference tick in LAG_WAIT_SECOND loads the held value into the counter and returns to LAG_IDLE.

Until that load, reads return the old count.

Top module: `match_timer`

## Requirements
- R1: After reset, the run register reads 0, every control word reads 0, every counter reads 0, every compare register reads 0xFFFFFFFF, and `irq`, `dma_req` and `irq_any` are low.
- R2: The run register sits at byte address 0x00. Channel n's registers sit at 0x10+n*0x10 (control), +0x04 (counter) and +0x08 (compare). Control fields read back as written: bit 8 clear-on-match mode, bit 7 interrupt enable, bits 5:4 request type, bits 2:0 clock select. The other writable bits read 0.
- R3: Clock select code 7 counts every reference tick. Code 4 counts every 8th tick, code 5 every 32nd and code 6 every 128th. Codes 0 to 3 stop counting.
- R4: On a count tick where the counter equals the compare value, bit 15 (match flag) sets. With bit 8 set, the counter returns to 0, so one period is compare+1 count ticks.
- R5: With bit 8 clear, a match sets the flag and the counter keeps incrementing past the compare value.
- R6: On a count tick that takes the counter from 0xFFFFFFFF to 0 without a match, bit 14 (overflow flag) sets.
- R7: Writing 0 to bit 15 or bit 14 of a control word clears that flag. Writing 1 leaves it unchanged. Software cannot set a flag.
- R8: `irq[n]` is high when channel n's match flag is set, its request type is 2 and its interrupt enable is set. `dma_req[n]` is high when the match flag is set and the request type is 1. `irq_any` is high when any `irq` bit is high. Writing 0 to a control word drops both outputs.
- R9: Bit n of the run register enables channel n. A stopped channel holds its count. A restarted channel resumes from the held value on its next prescaled tick.
- R10: A counter write takes effect on the second reference rising edge after it, and reads return the old value until then. A further write before that edge restarts the wait with the newer value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Slow reference clock, asynchronous to clk |
| bus_wr | input | 1 | Write strobe for one clk cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq | output | 4 | Per-channel interrupt request |
| dma_req | output | 4 | Per-channel DMA request |
| irq_any | output | 1 | OR of all interrupt requests |

## Verification
The periodic pattern uses a compare value of 5 in clear-on-match mode. Its check points fall one tick before and one tick after the match, which separates an off-by-one period from a correct period of compare+1. A free-running channel is preloaded near all ones with a small compare value. This keeps the overflow flag apart from the match flag and proves that counting continues past a match when clear-on-match is off. The divider pattern samples one tick short of each divisor and then on it, for two divisors and one invalid code. The lag pattern reads the counter before, between and after the two reference edges, with a second write inside the window to show that the wait restarts.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;

    localparam int CTL_MATCH_BIT = 15;
    localparam int CTL_OVF_BIT   = 14;
    localparam int CTL_MODE_BIT  = 8;
    localparam int CTL_IE_BIT    = 7;
    localparam int CTL_REQ_LO    = 4;
    localparam int CTL_CKS_LO    = 0;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_DMA  = 2'd1,
        REQ_IRQ  = 2'd2,
        REQ_RSVD = 2'd3
    } req_sel_e;

    typedef enum logic [1:0] {
        LAG_IDLE        = 2'd0,
        LAG_WAIT_FIRST  = 2'd1,
        LAG_WAIT_SECOND = 2'd2
    } lag_state_e;

    // terminal value of the prescaler count for each clock select code
    function automatic int div_limit(input logic [2:0] cks);
        case (cks)
            3'd4:    return 7;
            3'd5:    return 31;
            3'd6:    return 127;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/mt_ref_sync.sv
module mt_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    output logic ref_tick
);
    logic [STAGES:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-1:0], ref_clk};
    end

    // rising edge seen after the synchroniser stages
    assign ref_tick = shift_q[STAGES-1] & ~shift_q[STAGES];
endmodule

// File: rtl/mt_prescale.sv
module mt_prescale
    import match_timer_pkg::*;
#(
    parameter int MAX_DIV = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       run,
    input  logic [2:0] cks,
    output logic       cnt_tick
);
    localparam int PW = $clog2(MAX_DIV);

    logic [PW-1:0] div_q;
    logic [PW-1:0] lim;
    logic          valid;

    always_comb begin
        lim   = PW'(div_limit(cks));
        valid = cks[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  div_q <= '0;
        else if (!run)               div_q <= '0;
        else if (ref_tick && valid)  div_q <= (div_q == lim) ? '0 : div_q + 1'b1;
    end

    assign cnt_tick = run && ref_tick && valid && (div_q == lim);
endmodule

// File: rtl/mt_channel.sv
module mt_channel
    import match_timer_pkg::*;
#(
    parameter int CW      = 32,
    parameter int MAX_DIV = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_tick,
    input  logic          run,
    input  logic          wr_ctl,
    input  logic          wr_cnt,
    input  logic          wr_cmp,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] ctl_word,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cmp_q,
    output logic          irq,
    output logic          dma,
    output logic          match_f,
    output logic          ovf_f,
    output logic          cnt_tick,
    output logic          commit
);
    lag_state_e    state_q, state_d;
    logic [CW-1:0] pend_q;
    logic          mode_q, ie_q;
    req_sel_e      req_q;
    logic [2:0]    cks_q;
    logic          hit, at_top;

    mt_prescale #(.MAX_DIV(MAX_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .run      (run),
        .cks      (cks_q),
        .cnt_tick (cnt_tick)
    );

    // write-lag state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LAG_IDLE:        if (wr_cnt) state_d = LAG_WAIT_FIRST;
            LAG_WAIT_FIRST:  if (wr_cnt) state_d = LAG_WAIT_FIRST;
                             else if (ref_tick) state_d = LAG_WAIT_SECOND;
            LAG_WAIT_SECOND: if (wr_cnt) state_d = LAG_WAIT_FIRST;
                             else if (ref_tick) state_d = LAG_IDLE;
            default:         state_d = LAG_IDLE;
        endcase
    end

    assign commit = (state_q == LAG_WAIT_SECOND) && ref_tick && !wr_cnt;
    assign hit    = (cnt_q == cmp_q);
    assign at_top = (cnt_q == {CW{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            cnt_q   <= '0;
            cmp_q   <= '1;
            mode_q  <= 1'b0;
            ie_q    <= 1'b0;
            req_q   <= REQ_NONE;
            cks_q   <= '0;
            match_f <= 1'b0;
            ovf_f   <= 1'b0;
        end else begin
            if (wr_cnt) pend_q <= wdata;
            if (wr_cmp) cmp_q  <= wdata;
            if (commit)
                cnt_q <= pend_q;
            else if (cnt_tick)
                cnt_q <= (hit && mode_q) ? '0 : cnt_q + 1'b1;
            if (wr_ctl) begin
                mode_q <= wdata[CTL_MODE_BIT];
                ie_q   <= wdata[CTL_IE_BIT];
                req_q  <= req_sel_e'(wdata[CTL_REQ_LO +: 2]);
                cks_q  <= wdata[CTL_CKS_LO +: 3];
            end
            // hardware set takes priority over a software clear
            match_f <= (match_f & ~(wr_ctl & ~wdata[CTL_MATCH_BIT]))
                     | (cnt_tick & ~commit & hit);
            ovf_f   <= (ovf_f & ~(wr_ctl & ~wdata[CTL_OVF_BIT]))
                     | (cnt_tick & ~commit & ~hit & at_top);
        end
    end

    // outputs
    always_comb begin
        ctl_word                     = '0;
        ctl_word[CTL_MATCH_BIT]      = match_f;
        ctl_word[CTL_OVF_BIT]        = ovf_f;
        ctl_word[CTL_MODE_BIT]       = mode_q;
        ctl_word[CTL_IE_BIT]         = ie_q;
        ctl_word[CTL_REQ_LO +: 2]    = req_q;
        ctl_word[CTL_CKS_LO +: 3]    = cks_q;
        irq = match_f && ie_q && (req_q == REQ_IRQ);
        dma = match_f && (req_q == REQ_DMA);
    end
endmodule

// File: rtl/match_timer.sv
module match_timer #(
    parameter int NCH     = 4,
    parameter int CW      = 32,
    parameter int AW      = 8,
    parameter int MAX_DIV = 128
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_clk,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [CW-1:0]  bus_wdata,
    output logic [CW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq,
    output logic [NCH-1:0] dma_req,
    output logic           irq_any
);
    localparam int BLK_W = AW - 4;

    logic           ref_tick;
    logic [NCH-1:0] run_q;
    logic [NCH-1:0] ch_hit, ch_match, ch_ovf, ch_tick, ch_commit;
    logic [CW-1:0]  ch_ctl [NCH];
    logic [CW-1:0]  ch_cnt [NCH];
    logic [CW-1:0]  ch_cmp [NCH];
    logic [1:0]     reg_off;
    logic           run_sel;

    assign reg_off = bus_addr[3:2];
    assign run_sel = (bus_addr == '0);

    mt_ref_sync #(.STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_clk  (ref_clk),
        .ref_tick (ref_tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run_q <= '0;
        else if (bus_wr && run_sel) run_q <= bus_wdata[NCH-1:0];
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign ch_hit[n] = (bus_addr[AW-1:4] == BLK_W'(n + 1));
        mt_channel #(.CW(CW), .MAX_DIV(MAX_DIV)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .ref_tick (ref_tick),
            .run      (run_q[n]),
            .wr_ctl   (bus_wr && ch_hit[n] && reg_off == 2'd0),
            .wr_cnt   (bus_wr && ch_hit[n] && reg_off == 2'd1),
            .wr_cmp   (bus_wr && ch_hit[n] && reg_off == 2'd2),
            .wdata    (bus_wdata),
            .ctl_word (ch_ctl[n]),
            .cnt_q    (ch_cnt[n]),
            .cmp_q    (ch_cmp[n]),
            .irq      (irq[n]),
            .dma      (dma_req[n]),
            .match_f  (ch_match[n]),
            .ovf_f    (ch_ovf[n]),
            .cnt_tick (ch_tick[n]),
            .commit   (ch_commit[n])
        );
    end

    assign irq_any = |irq;

    always_comb begin
        bus_rdata = '0;
        if (run_sel) bus_rdata = CW'(run_q);
        for (int n = 0; n < NCH; n++) begin
            if (ch_hit[n]) begin
                case (reg_off)
                    2'd0:    bus_rdata = ch_ctl[n];
                    2'd1:    bus_rdata = ch_cnt[n];
                    2'd2:    bus_rdata = ch_cmp[n];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
    parameter int NCH = 4,
    parameter int CW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           irq_any,
    input logic [NCH-1:0] run_q,
    input logic [NCH-1:0] ch_match,
    input logic [NCH-1:0] ch_ovf,
    input logic [NCH-1:0] ch_tick,
    input logic [NCH-1:0] ch_commit,
    input logic [CW-1:0]  ch_cnt [NCH]
);
    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (ch_match != '0));

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        // R4
        match_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_match[n]) |-> $past(ch_tick[n]));
        // R6
        ovf_from_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_ovf[n]) |-> ($past(ch_tick[n]) && $past(ch_cnt[n]) == {CW{1'b1}}));
        // R9
        stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_q[n] && !ch_commit[n]) |=> ch_cnt[n] == $past(ch_cnt[n]));
    end
endmodule

bind match_timer match_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_any   (irq_any),
    .run_q     (run_q),
    .ch_match  (ch_match),
    .ch_ovf    (ch_ovf),
    .ch_tick   (ch_tick),
    .ch_commit (ch_commit),
    .ch_cnt    (ch_cnt)
);

// File: tb/match_timer_bench.sv
module match_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_clk = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq, dma_req;
    logic        irq_any;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    match_timer u_match_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_clk   (ref_clk),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .dma_req   (dma_req),
        .irq_any   (irq_any)
    );

    function automatic logic [7:0] ra(input int ch, input int off);
        return 8'(16 + ch * 16 + off * 4);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 check(tag, bus_rdata, exp);
    endtask

    task automatic pulses(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk) ref_clk = 1'b1;
            repeat (5) @(negedge clk);
            ref_clk = 1'b0;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic t_reset;
        rd_chk("R1 run reg", 8'h00, 32'h0);
        rd_chk("R1 ctl ch0", ra(0, 0), 32'h0);
        rd_chk("R1 cnt ch1", ra(1, 1), 32'h0);
        rd_chk("R1 cmp ch0", ra(0, 2), 32'hFFFF_FFFF);
        rd_chk("R1 cmp ch3", ra(3, 2), 32'hFFFF_FFFF);
        check("R1 outputs", {23'b0, irq, dma_req, irq_any}, 32'h0);
    endtask

    task automatic t_map;
        wr(ra(2, 2), 32'h0000_1234);
        rd_chk("R2 cmp ch2", ra(2, 2), 32'h0000_1234);
        rd_chk("R2 cmp ch1 untouched", ra(1, 2), 32'hFFFF_FFFF);
        wr(ra(2, 0), 32'h0000_C1B7);
        rd_chk("R2 ctl fields", ra(2, 0), 32'h0000_01B7);
        wr(ra(2, 0), 32'h0);
        rd_chk("R2 ctl cleared", ra(2, 0), 32'h0);
    endtask

    task automatic t_periodic;
        wr(ra(0, 0), 32'h0000_01A7);
        wr(ra(0, 2), 32'd5);
        wr(8'h00, 32'h1);
        pulses(5);
        rd_chk("R4 before match cnt", ra(0, 1), 32'd5);
        rd_chk("R4 before match ctl", ra(0, 0), 32'h0000_01A7);
        check("R8 irq low before match", {31'b0, irq_any}, 32'h0);
        pulses(1);
        rd_chk("R4 wrap to zero", ra(0, 1), 32'd0);
        rd_chk("R4 match flag", ra(0, 0), 32'h0000_81A7);
        check("R8 irq ch0", {28'b0, irq}, 32'h1);
        check("R8 irq_any", {31'b0, irq_any}, 32'h1);
        check("R8 no dma", {28'b0, dma_req}, 32'h0);
        pulses(6);
        rd_chk("R4 second period", ra(0, 1), 32'd0);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_flag_clear;
        wr(ra(0, 0), 32'h0000_81A7);
        rd_chk("R7 write 1 keeps flag", ra(0, 0), 32'h0000_81A7);
        check("R8 irq still set", {31'b0, irq_any}, 32'h1);
        wr(ra(0, 0), 32'h0);
        rd_chk("R7 write 0 clears", ra(0, 0), 32'h0);
        check("R8 irq dropped by zero write", {28'b0, irq}, 32'h0);
    endtask

    task automatic t_divider;
        wr(ra(1, 0), 32'h0000_0004);
        wr(8'h00, 32'h2);
        pulses(7);
        rd_chk("R3 div8 short", ra(1, 1), 32'd0);
        pulses(1);
        rd_chk("R3 div8 tick", ra(1, 1), 32'd1);
        wr(ra(1, 0), 32'h0000_0005);
        pulses(31);
        rd_chk("R3 div32 short", ra(1, 1), 32'd1);
        pulses(1);
        rd_chk("R3 div32 tick", ra(1, 1), 32'd2);
        wr(ra(1, 0), 32'h0000_0003);
        pulses(10);
        rd_chk("R3 invalid code stops", ra(1, 1), 32'd2);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_lag;
        wr(ra(2, 0), 32'h0000_0007);
        wr(ra(2, 1), 32'd100);
        rd_chk("R10 old value at once", ra(2, 1), 32'd0);
        pulses(1);
        rd_chk("R10 old after one edge", ra(2, 1), 32'd0);
        pulses(1);
        rd_chk("R10 new after two edges", ra(2, 1), 32'd100);
        wr(ra(2, 1), 32'd200);
        pulses(1);
        wr(ra(2, 1), 32'd300);
        pulses(1);
        rd_chk("R10 rewrite restarts wait", ra(2, 1), 32'd100);
        pulses(1);
        rd_chk("R10 newest value lands", ra(2, 1), 32'd300);
    endtask

    task automatic t_overflow;
        wr(ra(3, 0), 32'h0000_0007);
        wr(ra(3, 2), 32'd3);
        wr(ra(3, 1), 32'hFFFF_FFFE);
        pulses(2);
        wr(8'h00, 32'h8);
        pulses(1);
        rd_chk("R6 at top", ra(3, 1), 32'hFFFF_FFFF);
        rd_chk("R6 no flag yet", ra(3, 0), 32'h0000_0007);
        pulses(1);
        rd_chk("R6 wrapped", ra(3, 1), 32'd0);
        rd_chk("R6 ovf flag", ra(3, 0), 32'h0000_4007);
        pulses(4);
        rd_chk("R5 counts past match", ra(3, 1), 32'd4);
        rd_chk("R5 match flag free-run", ra(3, 0), 32'h0000_C007);
        wr(ra(3, 0), 32'h0000_C017);
        check("R8 dma ch3", {28'b0, dma_req}, 32'h8);
        check("R8 dma no irq", {31'b0, irq_any}, 32'h0);
        wr(ra(3, 0), 32'h0000_4017);
        rd_chk("R7 clear match keep ovf", ra(3, 0), 32'h0000_4017);
        check("R8 dma dropped", {28'b0, dma_req}, 32'h0);
        wr(ra(3, 0), 32'h0000_8007);
        rd_chk("R7 clear ovf", ra(3, 0), 32'h0000_0007);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_hold;
        wr(ra(0, 0), 32'h0000_0007);
        wr(8'h00, 32'h1);
        rd_chk("R9 run reg readback", 8'h00, 32'h1);
        pulses(3);
        rd_chk("R9 running", ra(0, 1), 32'd3);
        wr(8'h00, 32'h0);
        pulses(4);
        rd_chk("R9 stopped holds", ra(0, 1), 32'd3);
        rd_chk("R9 other channel held", ra(1, 1), 32'd2);
        wr(8'h00, 32'h1);
        pulses(1);
        rd_chk("R9 resumes from held", ra(0, 1), 32'd4);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_map();
        t_periodic();
        t_flag_clear();
        t_divider();
        t_lag();
        t_overflow();
        t_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule